// File: doc/BRIEF.md
# Toggle-Stepped Debug Observation Multiplexer

This block lets a small number of chip pins look at a large number of internal signals. The internal signals reach it as one flat observation bus made of equal groups. The block drives one group at a time onto a narrow registered output. In the default configuration there are sixteen groups of six bits, so ninety-six signals are visible through six output pins plus one control pin.

The group shown is chosen by a counter. A single external step pin moves the counter forward by one group each time the pin changes level, so both rising and falling transitions count. A tester walks through the groups by toggling that one pin. The pin is asynchronous to the block clock. It passes through a two-flop synchronizer before its transitions are detected. After the last group the counter returns to group 0.

Top module: `toggle_obs_mux`

## Requirements
- R1: While `rstN` is low, `obsOut` is all zeros and the group counter is at group 0. Reset treats the step pin's reference level as low. From the first cycle after reset, `obsOut` shows group 0.
- R2: Group k is carried on `obsBus` bits 6k+5 down to 6k. When group k is selected, `obsOut` equals exactly that slice.
- R3: A low-to-high transition of `stepPin` moves the selection forward by exactly one group.
- R4: A high-to-low transition of `stepPin` moves the selection forward by exactly one group.
- R5: One transition while group 15 is selected selects group 0.
- R6: After a transition of `stepPin` just after a clock edge, `obsOut` still shows the old group after three rising clock edges. It shows the next group after the fourth.
- R7: `obsOut` is registered. A change on `obsBus` in the selected group appears on `obsOut` one rising clock edge later.
- R8: While `stepPin` holds a steady level, the selection does not change, however many cycles pass.
- R9: A pulse on `stepPin` that lasts exactly one clock period counts as two transitions and advances the selection by two groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| obsBus | input | 96 | Flat observation bus; group k in bits 6k+5:6k |
| stepPin | input | 1 | Asynchronous step pin; every level change advances the group |
| obsOut | output | 6 | Registered view of the selected group |

## Verification
The bound checker checks on every cycle that the group counter steps by one on each detected transition and wraps from the last group to the first. It also checks that the counter holds when no transition is detected, that `obsOut` carries the previously selected slice one cycle later, and that `obsOut` is zero during reset. Only the bench scenarios can show the behaviour at the pin. These cover the exact four-edge latency from a pin change, the counting of both edge directions, the doubled step from a one-cycle pulse, and a walk through every group more than twice with the bus contents changing along the way.

// File: rtl/obs_pkg.sv
package obs_pkg;
  // Strobes handed from the control side to the datapath.
  typedef struct packed {
    logic advance;
  } obsCtrl_t;
endpackage

// File: rtl/obs_sync.sv
module obs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/obs_ctrl.sv
module obs_ctrl
  import obs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     stepPin,
  output obsCtrl_t ctrl
);
  logic syncLevel;
  logic lastLevel;

  obs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(stepPin),
    .syncOut(syncLevel)
  );

  // Reference level follows the synchronized pin; a mismatch is one toggle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= syncLevel;
  end

  always_comb begin
    ctrl         = '0;
    ctrl.advance = syncLevel ^ lastLevel;
  end
endmodule

// File: rtl/obs_datapath.sv
module obs_datapath
  import obs_pkg::*;
#(
  parameter int GROUP_COUNT = 16,
  parameter int GROUP_W     = 6,
  localparam int BUS_W      = GROUP_COUNT * GROUP_W,
  localparam int SEL_W      = (GROUP_COUNT > 1) ? $clog2(GROUP_COUNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  obsCtrl_t           ctrl,
  input  logic [BUS_W-1:0]   obsBus,
  output logic [SEL_W-1:0]   groupSel,
  output logic [GROUP_W-1:0] obsOut
);
  localparam logic [SEL_W-1:0] LAST_GROUP = SEL_W'(GROUP_COUNT - 1);

  logic [GROUP_W-1:0] slices [GROUP_COUNT];

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_slice
    assign slices[g] = obsBus[g*GROUP_W +: GROUP_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      groupSel <= '0;
    end else if (ctrl.advance) begin
      if (groupSel == LAST_GROUP) groupSel <= '0;
      else                        groupSel <= groupSel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) obsOut <= '0;
    else       obsOut <= slices[groupSel];
  end
endmodule

// File: rtl/toggle_obs_mux.sv
module toggle_obs_mux
  import obs_pkg::*;
#(
  parameter int GROUP_COUNT = 16,
  parameter int GROUP_W     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = GROUP_COUNT * GROUP_W,
  localparam int SEL_W      = (GROUP_COUNT > 1) ? $clog2(GROUP_COUNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BUS_W-1:0]   obsBus,
  input  logic               stepPin,
  output logic [GROUP_W-1:0] obsOut
);
  obsCtrl_t         ctrlStrobes;
  logic [SEL_W-1:0] groupSel;

  obs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stepPin(stepPin),
    .ctrl   (ctrlStrobes)
  );

  obs_datapath #(.GROUP_COUNT(GROUP_COUNT), .GROUP_W(GROUP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlStrobes),
    .obsBus  (obsBus),
    .groupSel(groupSel),
    .obsOut  (obsOut)
  );
endmodule

// File: rtl/obs_checker.sv
module obs_checker #(
  parameter int GROUP_COUNT = 16,
  parameter int GROUP_W     = 6,
  localparam int BUS_W      = GROUP_COUNT * GROUP_W,
  localparam int SEL_W      = (GROUP_COUNT > 1) ? $clog2(GROUP_COUNT) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [BUS_W-1:0]   obsBus,
  input logic [GROUP_W-1:0] obsOut,
  input logic [SEL_W-1:0]   groupSel,
  input logic               advance
);
  localparam logic [SEL_W-1:0] LAST_GROUP = SEL_W'(GROUP_COUNT - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (obsOut == '0));

  assert_slice_routed_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (obsOut == $past(obsBus[groupSel*GROUP_W +: GROUP_W])));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && groupSel != LAST_GROUP) |=> (groupSel == SEL_W'($past(groupSel) + 1'b1)));

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && groupSel == LAST_GROUP) |=> (groupSel == '0));

  assert_hold_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(groupSel));
endmodule

bind toggle_obs_mux obs_checker #(.GROUP_COUNT(GROUP_COUNT), .GROUP_W(GROUP_W)) u_obs_checker (
  .clk     (clk),
  .rstN    (rstN),
  .obsBus  (obsBus),
  .obsOut  (obsOut),
  .groupSel(groupSel),
  .advance (ctrlStrobes.advance)
);

// File: tb/test_toggle_obs_mux.sv
module test_toggle_obs_mux;
  localparam int GC = 16;
  localparam int GW = 6;
  localparam int BW = GC * GW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [BW-1:0] obsBus;
  logic          stepPin = 1'b0;
  logic [GW-1:0] obsOut;

  int vectors = 0;
  int misses  = 0;
  int expGroup = 0;
  int seed = 7;
  bit done = 1'b0;

  always #2 clk = ~clk;

  toggle_obs_mux i_toggle_obs_mux (
    .clk    (clk),
    .rstN   (rstN),
    .obsBus (obsBus),
    .stepPin(stepPin),
    .obsOut (obsOut)
  );

  // Slice k holds (5k + seed) mod 64: distinct across the sixteen groups.
  function automatic logic [BW-1:0] makeBus(int s);
    logic [BW-1:0] b;
    for (int k = 0; k < GC; k++) b[k*GW +: GW] = GW'(k * 5 + s);
    return b;
  endfunction

  function automatic logic [GW-1:0] slotVal(int s, int g);
    return GW'(g * 5 + s);
  endfunction

  task automatic check(string req, logic [GW-1:0] act, logic [GW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: obsOut=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flipPin();
    stepPin = ~stepPin;
    expGroup = (expGroup + 1) % GC;
  endtask

  initial begin
    obsBus = makeBus(seed);
    // R1: outputs cleared in reset
    edges(3);
    check("R1 in reset", obsOut, '0);
    rstN = 1'b1;
    edges(2);
    check("R1 group0 after reset", obsOut, slotVal(seed, 0));
    check("R2 slice of group 0", obsOut, obsBus[5:0]);

    // R7: registered bus path
    seed = 21;
    obsBus = makeBus(seed);
    edges(1);
    check("R7 bus change one edge later", obsOut, slotVal(seed, 0));

    // R6 and R3: exact latency of a rising transition
    flipPin();
    edges(3);
    check("R6 old group after three edges", obsOut, slotVal(seed, 0));
    edges(1);
    check("R6 new group after four edges", obsOut, slotVal(seed, 1));
    check("R3 rising step", obsOut, slotVal(seed, expGroup));

    // Sweep more than two full laps, both edge directions, wrap and bus changes
    for (int n = 0; n < 2 * GC + 3; n++) begin
      flipPin();
      if (n % 5 == 0) begin
        seed = (seed + 13) % 64;
        obsBus = makeBus(seed);
      end
      edges(6);
      if (expGroup == 0)      check("R5 wrap to group 0", obsOut, slotVal(seed, expGroup));
      else if (stepPin)       check("R3 rising step", obsOut, slotVal(seed, expGroup));
      else                    check("R4 falling step", obsOut, slotVal(seed, expGroup));
      check("R2 slice position", obsOut, obsBus[expGroup*GW +: GW]);
    end

    // R8: steady pin holds the selection
    for (int n = 0; n < 4; n++) begin
      edges(15);
      check("R8 steady pin holds group", obsOut, slotVal(seed, expGroup));
    end

    // R9: one-period pulse counts twice
    flipPin();
    edges(1);
    flipPin();
    edges(8);
    check("R9 one-cycle pulse advances two", obsOut, slotVal(seed, expGroup));

    // R1: mid-run reset returns to group 0 (pin low first)
    if (stepPin) begin flipPin(); edges(8); end
    if (expGroup == 0) begin flipPin(); flipPin(); edges(10); end
    rstN = 1'b0;
    edges(1);
    check("R1 cleared on mid-run reset", obsOut, '0);
    rstN = 1'b1;
    expGroup = 0;
    edges(2);
    check("R1 group0 after mid-run reset", obsOut, slotVal(seed, 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule